// File: doc/BRIEF.md
# Flash Status and Write-Protect Gate

This block keeps the status byte of a small serial flash device and rules on every decoded instruction whether it may run. An upstream decoder hands it a one-cycle strobe with an instruction type, a 17-bit target address, a data byte and the level of the active-low write-protect pin. The block answers, one clock later, with either an accept or a reject pulse and updates the status byte that a read-status instruction returns.

Protection is layered. A write-enable latch must be armed before any modifying instruction. Two block-protect bits shield an upper part of the array from program and block erase, and they must both be clear before a chip erase runs. A write-disable bit, combined with a low write-protect pin, freezes the protection bits themselves. An internal down counter stands in for the time an accepted write, program or erase keeps the device busy. While it runs, only status reads get through.

Two resets are provided. `rst_n` clears the volatile state: busy, latch, counter and flags. `por_n` additionally clears the protection bits, which otherwise survive a volatile reset.

Top module: `flash_guard`

## Requirements
- R1: After `por_n` the status byte is 0x00. Its layout is bit 0 busy, bit 1 write-enable latch, bits 3:2 block-protect, bit 7 write-disable. Bits 6:4 always read 0, and a status write sets only bits 7 and 3:2 from the data byte.
- R2: Type 1 (write enable) sets the latch and type 2 (write disable) clears it. Type 0 (read status) is accepted and changes nothing. All three are accepted.
- R3: With the latch clear, type 3 (status write), type 4 (page program), type 5 (block erase) and type 6 (chip erase) are rejected and start no busy period.
- R4: An accepted type 3, 4, 5 or 6 holds busy high for exactly T_STAT_WR, T_PROG, T_BLK_ERASE or T_CHIP_ERASE cycles (defaults 8, 16, 32, 64). The latch clears when busy falls.
- R5: While busy, read status is accepted. Every other type gets neither accept nor reject and changes no status bit.
- R6: Block-protect 01 shields addresses 0x18000 and up, 10 shields 0x10000 and up, and 11 shields the whole array. Page program or block erase to a shielded address is rejected, and that rejection clears the latch.
- R7: Chip erase is accepted only when both block-protect bits are 0. Otherwise it is rejected.
- R8: When the write-disable bit is 1 and `wp_n` is low, a status write is rejected and bits 7 and 3:2 keep their value. With `wp_n` high the same write is accepted.
- R9: `rst_n` clears busy and the latch but keeps the write-disable and block-protect bits. `por_n` clears them as well.
- R10: The accept and reject pulses last one cycle, appear in the cycle after the strobe, and never occur together. Type 7 is rejected and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Volatile reset, active low, keeps protection bits |
| cmd_valid | input | 1 | One-cycle strobe of a decoded instruction |
| cmd_op | input | 3 | Instruction type code (0 to 7, see requirements) |
| cmd_addr | input | ADDR_W (17) | Target byte address for program and block erase |
| cmd_data | input | 8 | Data byte for status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Current status byte |
| cmd_accept | output | 1 | Instruction accepted (pulse) |
| cmd_reject | output | 1 | Instruction rejected (pulse) |

## Verification
Each modifying type is tried with the latch clear and then with the latch set. This separates latch gating from protection gating. Program and erase are aimed just below and just above each region boundary under each block-protect setting, which exposes off-by-one or swapped region decodes. Status writes are tried under all four combinations of write-disable and the pin, and instructions are issued mid-busy, to separate hardware-protect and busy blocking from ordinary rejection. The busy length is counted per type, and the two resets are pulsed with protection bits set, to tell the counter load and the reset domains apart.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

    typedef enum logic [2:0] {
        OP_STAT_RD    = 3'd0,
        OP_WR_EN      = 3'd1,
        OP_WR_DIS     = 3'd2,
        OP_STAT_WR    = 3'd3,
        OP_PAGE_PROG  = 3'd4,
        OP_BLK_ERASE  = 3'd5,
        OP_CHIP_ERASE = 3'd6,
        OP_UNUSED     = 3'd7
    } fg_op_e;

    localparam int unsigned STAT_W   = 8;
    localparam int unsigned BIT_BUSY = 0;
    localparam int unsigned BIT_WEL  = 1;
    localparam int unsigned BIT_BP0  = 2;
    localparam int unsigned BIT_BP1  = 3;
    localparam int unsigned BIT_WDIS = 7;

endpackage

// File: rtl/fg_region_check.sv
`timescale 1ns/1ps
module fg_region_check #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = addr[TOP] & addr[TOP-1];
            2'b10:   hit = addr[TOP];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/fg_busy_timer.sv
`timescale 1ns/1ps
module fg_busy_timer
    import flash_guard_pkg::*;
#(
    parameter int unsigned T_STAT_WR    = 8,
    parameter int unsigned T_PROG       = 16,
    parameter int unsigned T_BLK_ERASE  = 32,
    parameter int unsigned T_CHIP_ERASE = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  fg_op_e op,
    output logic   busy,
    output logic   done
);
    localparam int unsigned MAX_AB = (T_STAT_WR > T_PROG) ? T_STAT_WR : T_PROG;
    localparam int unsigned MAX_CD = (T_BLK_ERASE > T_CHIP_ERASE) ? T_BLK_ERASE : T_CHIP_ERASE;
    localparam int unsigned MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W  = (MAX_T > 1) ? $clog2(MAX_T) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    function automatic logic [CNT_W-1:0] load_for(input fg_op_e o);
        case (o)
            OP_STAT_WR:   return CNT_W'(T_STAT_WR - 1);
            OP_PAGE_PROG: return CNT_W'(T_PROG - 1);
            OP_BLK_ERASE: return CNT_W'(T_BLK_ERASE - 1);
            default:      return CNT_W'(T_CHIP_ERASE - 1);
        endcase
    endfunction

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = load_for(op);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != '0) |=> tmr_q.busy);
    p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/fg_status_regs.sv
`timescale 1ns/1ps
module fg_status_regs (
    input  logic       clk,
    input  logic       vol_rst_n,
    input  logic       por_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       nv_we,
    input  logic [7:0] nv_data,
    output logic       wel,
    output logic       wdis,
    output logic [1:0] bp
);
    typedef struct packed {
        logic       wdis;
        logic [1:0] bp;
    } nv_t;

    logic wel_d, wel_q;
    nv_t  nv_d, nv_q;

    always_comb begin
        wel_d = wel_q;
        if (wel_set)      wel_d = 1'b1;
        else if (wel_clr) wel_d = 1'b0;
        nv_d = nv_q;
        if (nv_we) begin
            nv_d.wdis = nv_data[7];
            nv_d.bp   = nv_data[3:2];
        end
    end

    always_ff @(posedge clk or negedge vol_rst_n) begin
        if (!vol_rst_n) wel_q <= 1'b0;
        else            wel_q <= wel_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) nv_q <= '0;
        else        nv_q <= nv_d;
    end

    assign wel  = wel_q;
    assign wdis = nv_q.wdis;
    assign bp   = nv_q.bp;

    p_wel_set_r2: assert property (@(posedge clk) disable iff (!vol_rst_n)
        wel_set |=> wel);
    p_wel_clr_r2: assert property (@(posedge clk) disable iff (!vol_rst_n)
        (wel_clr && !wel_set) |=> !wel);
    p_nv_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        !nv_we |=> $stable({wdis, bp}));
endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int unsigned ADDR_W       = 17,
    parameter int unsigned T_STAT_WR    = 8,
    parameter int unsigned T_PROG       = 16,
    parameter int unsigned T_BLK_ERASE  = 32,
    parameter int unsigned T_CHIP_ERASE = 64
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              cmd_accept,
    output logic              cmd_reject
);
    typedef struct packed {
        logic acc;
        logic rej;
    } flag_t;

    fg_op_e     op;
    logic       vol_rst_n;
    logic       busy, done, hit, hw_lock;
    logic       wel, wdis;
    logic [1:0] bp;
    logic       start, wel_set, dec_wel_clr, nv_we;
    flag_t      flag_d, flag_q;

    assign op        = fg_op_e'(cmd_op);
    assign vol_rst_n = rst_n & por_n;
    assign hw_lock   = wdis & ~wp_n;

    fg_region_check #(.ADDR_W(ADDR_W)) u_region (
        .bp   (bp),
        .addr (cmd_addr),
        .hit  (hit)
    );

    fg_busy_timer #(
        .T_STAT_WR    (T_STAT_WR),
        .T_PROG       (T_PROG),
        .T_BLK_ERASE  (T_BLK_ERASE),
        .T_CHIP_ERASE (T_CHIP_ERASE)
    ) u_timer (
        .clk   (clk),
        .rst_n (vol_rst_n),
        .start (start),
        .op    (op),
        .busy  (busy),
        .done  (done)
    );

    fg_status_regs u_regs (
        .clk       (clk),
        .vol_rst_n (vol_rst_n),
        .por_n     (por_n),
        .wel_set   (wel_set),
        .wel_clr   (dec_wel_clr | done),
        .nv_we     (nv_we),
        .nv_data   (cmd_data),
        .wel       (wel),
        .wdis      (wdis),
        .bp        (bp)
    );

    // Decision: every next value computed here, registered below.
    always_comb begin
        flag_d      = '0;
        start       = 1'b0;
        wel_set     = 1'b0;
        dec_wel_clr = 1'b0;
        nv_we       = 1'b0;
        if (cmd_valid) begin
            if (busy) begin
                flag_d.acc = (op == OP_STAT_RD);
            end else begin
                unique case (op)
                    OP_STAT_RD: flag_d.acc = 1'b1;
                    OP_WR_EN: begin
                        flag_d.acc = 1'b1;
                        wel_set    = 1'b1;
                    end
                    OP_WR_DIS: begin
                        flag_d.acc  = 1'b1;
                        dec_wel_clr = 1'b1;
                    end
                    OP_STAT_WR: begin
                        if (wel && !hw_lock) begin
                            flag_d.acc = 1'b1;
                            start      = 1'b1;
                            nv_we      = 1'b1;
                        end else begin
                            flag_d.rej  = 1'b1;
                            dec_wel_clr = 1'b1;
                        end
                    end
                    OP_PAGE_PROG, OP_BLK_ERASE: begin
                        if (wel && !hit) begin
                            flag_d.acc = 1'b1;
                            start      = 1'b1;
                        end else begin
                            flag_d.rej  = 1'b1;
                            dec_wel_clr = 1'b1;
                        end
                    end
                    OP_CHIP_ERASE: begin
                        if (wel && bp == 2'b00) begin
                            flag_d.acc = 1'b1;
                            start      = 1'b1;
                        end else begin
                            flag_d.rej  = 1'b1;
                            dec_wel_clr = 1'b1;
                        end
                    end
                    default: flag_d.rej = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge vol_rst_n) begin
        if (!vol_rst_n) flag_q <= '0;
        else            flag_q <= flag_d;
    end

    assign cmd_accept = flag_q.acc;
    assign cmd_reject = flag_q.rej;

    always_comb begin
        status           = '0;
        status[BIT_BUSY] = busy;
        status[BIT_WEL]  = wel;
        status[BIT_BP0]  = bp[0];
        status[BIT_BP1]  = bp[1];
        status[BIT_WDIS] = wdis;
    end

    p_wel_gate_r3: assert property (@(posedge clk) disable iff (!vol_rst_n)
        (cmd_valid && !busy && !wel && (op == OP_STAT_WR || op == OP_PAGE_PROG ||
         op == OP_BLK_ERASE || op == OP_CHIP_ERASE)) |=> (cmd_reject && !status[BIT_BUSY]));
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!vol_rst_n)
        (cmd_valid && busy && op != OP_STAT_RD) |=> (!cmd_accept && !cmd_reject));
    p_prot_reject_r6: assert property (@(posedge clk) disable iff (!vol_rst_n)
        (cmd_valid && !busy && hit && (op == OP_PAGE_PROG || op == OP_BLK_ERASE))
        |=> (cmd_reject && !status[BIT_WEL]));
    p_ce_clear_r7: assert property (@(posedge clk) disable iff (!vol_rst_n)
        (cmd_valid && !busy && op == OP_CHIP_ERASE && bp != 2'b00) |=> cmd_reject);
    p_hw_freeze_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wdis && !wp_n) |=> $stable({status[BIT_WDIS], status[BIT_BP1:BIT_BP0]}));
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!vol_rst_n)
        !(cmd_accept && cmd_reject));
    p_flag_pulse_r10: assert property (@(posedge clk) disable iff (!vol_rst_n)
        !cmd_valid |=> (!cmd_accept && !cmd_reject));
    p_zero_bits_r1: assert property (@(posedge clk) disable iff (!por_n)
        status[6:4] == 3'b000);
endmodule

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp_n = 1'b1;
    logic [7:0]    status;
    logic          cmd_accept, cmd_reject;

    int errors = 0;
    int checks = 0;
    logic got_acc, got_rej;

    always #4 clk = ~clk;

    flash_guard i_flash_guard (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // drive one strobe; flags and status are sampled one cycle later
    task automatic issue(input int op, input int addr, input int data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_addr  = AW'(addr);
        cmd_data  = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
        got_acc   = cmd_accept;
        got_rej   = cmd_reject;
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
    endtask

    task automatic set_prot(input int data);
        issue(1, 0, 0);
        issue(3, 0, data);
        wait_idle();
    endtask

    task automatic t_reset_state();
        chk("R1 status after power-on", status, 8'h00);
        set_prot(8'h73);
        chk("R1 bits 6:4 and busy/latch not written", status, 8'h00);
    endtask

    task automatic t_latch();
        issue(1, 0, 0);
        chk("R2 write enable accepted", got_acc, 1);
        chk("R2 latch set", status, 8'h02);
        issue(0, 0, 0);
        chk("R2 read status accepted", {got_acc, got_rej}, 2'b10);
        chk("R2 read status no change", status, 8'h02);
        issue(2, 0, 0);
        chk("R2 write disable clears latch", status, 8'h00);
    endtask

    task automatic t_no_latch();
        for (int op = 3; op <= 6; op++) begin
            issue(op, 0, 8'h0C);
            chk("R3 rejected without latch", {got_acc, got_rej}, 2'b01);
            chk("R3 no busy and no change", status, 8'h00);
        end
    endtask

    task automatic t_busy_len();
        int exp_len [4] = '{8, 16, 32, 64};
        for (int k = 0; k < 4; k++) begin
            int n = 0;
            issue(1, 0, 0);
            issue(3 + k, 0, 0);
            chk("R4 accepted when armed", got_acc, 1);
            while (status[0]) begin
                n++;
                @(negedge clk);
            end
            chk("R4 busy length", n, exp_len[k]);
            chk("R4 latch cleared at completion", status, 8'h00);
        end
    endtask

    task automatic t_busy_ignore();
        issue(1, 0, 0);
        issue(4, 0, 0);
        issue(2, 0, 0);
        chk("R5 write disable ignored while busy", {got_acc, got_rej}, 2'b00);
        chk("R5 latch kept while busy", status[1], 1);
        issue(6, 0, 0);
        chk("R5 chip erase ignored while busy", {got_acc, got_rej}, 2'b00);
        issue(0, 0, 0);
        chk("R5 read status accepted while busy", {got_acc, got_rej}, 2'b10);
        chk("R5 busy still shown", status[0], 1);
        wait_idle();
    endtask

    task automatic t_regions();
        set_prot(8'h04);
        issue(1, 0, 0);
        issue(4, 32'h17FFF, 0);
        chk("R6 bp01 below boundary accepted", got_acc, 1);
        wait_idle();
        issue(1, 0, 0);
        issue(4, 32'h18000, 0);
        chk("R6 bp01 top quarter rejected", got_rej, 1);
        chk("R6 reject clears latch", status, 8'h04);
        set_prot(8'h08);
        issue(1, 0, 0);
        issue(5, 32'h0FFFF, 0);
        chk("R6 bp10 lower half erase accepted", got_acc, 1);
        wait_idle();
        issue(1, 0, 0);
        issue(5, 32'h10000, 0);
        chk("R6 bp10 upper half erase rejected", got_rej, 1);
        issue(1, 0, 0);
        issue(6, 0, 0);
        chk("R7 chip erase rejected with bp10", got_rej, 1);
        set_prot(8'h0C);
        issue(1, 0, 0);
        issue(4, 0, 0);
        chk("R6 bp11 address 0 rejected", got_rej, 1);
        set_prot(8'h00);
        issue(1, 0, 0);
        issue(6, 0, 0);
        chk("R7 chip erase accepted with bp00", got_acc, 1);
        wait_idle();
    endtask

    task automatic t_hw_lock();
        set_prot(8'h80);
        chk("R8 write-disable bit set", status, 8'h80);
        wp_n = 1'b0;
        issue(1, 0, 0);
        issue(3, 0, 8'h0C);
        chk("R8 status write rejected when locked", got_rej, 1);
        chk("R8 bits frozen", status, 8'h80);
        wp_n = 1'b1;
        issue(1, 0, 0);
        issue(3, 0, 8'h0C);
        chk("R8 status write accepted with pin high", got_acc, 1);
        wait_idle();
        chk("R8 new bits written", status, 8'h0C);
    endtask

    task automatic t_resets();
        issue(1, 0, 0);
        chk("R9 latch armed before reset", status, 8'h0E);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9 volatile reset keeps protection", status, 8'h0C);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R9 power-on reset clears all", status, 8'h00);
    endtask

    task automatic t_flags();
        issue(1, 0, 0);
        issue(7, 0, 8'hFF);
        chk("R10 type 7 rejected", {got_acc, got_rej}, 2'b01);
        chk("R10 type 7 no change", status, 8'h02);
        @(negedge clk);
        chk("R10 flags are one-cycle pulses", {cmd_accept, cmd_reject}, 2'b00);
        issue(2, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_latch();
        t_no_latch();
        t_busy_len();
        t_busy_ignore();
        t_regions();
        t_hw_lock();
        t_resets();
        t_flags();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule